// File: doc/BRIEF.md
# USB Host Controller Operational Register Bank

This block holds the operational registers of a USB 2.0 host controller: command, status, interrupt enable, frame index and configure flag. Software reaches them through a plain 32-bit word bus. The bus has a select, a write strobe, a byte address, write data and combinational read data. Each register applies its own write rule. Status interrupt bits are cleared by writing a one. Reserved status bits ignore writes. The enable and configure registers keep only their defined bits. A controller-reset command bit clears itself.

Three small state machines derive the schedule status bits from the command register. The run machine has the states HALTED and ACTIVE. Its transitions are START (run bit written 0 to 1) and STOP (run bit written 1 to 0). While ACTIVE, a microframe timer advances the frame index. The periodic machine has the states OFF and ON. Its transitions are P_ENABLE and P_DISABLE, and they are taken only on a frame boundary. The async machine has the states OFF and ON. Its transitions are A_ENABLE and A_DISABLE, and they follow the async-enable bit one cycle later.

A schedule engine drives three event inputs:
- A set mask for the interrupt status bits.
- A schedule-start event, which sets the reclamation bit.
- A head-of-list event, which clears the reclamation bit. If the bit is already clear, the event produces a one-cycle done pulse instead.

A single level interrupt output reports any enabled interrupt status bit.

Top module: `usbh_opreg_bank`

## Requirements
- R1: Status register (byte offset 0x04): bits 5:0 are interrupt bits. Writing 1 to one of them clears it, and writing 0 leaves it unchanged. Writes to bits 31:6 have no effect. The read-only fields are HALTED at bit 12, reclamation at bit 13, periodic status at bit 14 and async status at bit 15. All other bits read 0.
- R2: irq is high exactly when (status bits 5:0 AND enable bits 5:0) is nonzero. It follows every status write, event and enable write in the cycle the register changes.
- R3: Command register (offset 0x00), run bit 0. A write changing run from 0 to 1 clears HALTED on the same clock edge and starts the frame index counting, one count per microframe tick. A write changing run from 1 to 0 sets HALTED and freezes the frame index. The frame index register (offset 0x0C) is 14 bits wide, is loadable by software and reads zero-extended.
- R4: Writing 1 to command bit 1 (controller reset) returns the following to their reset values on that edge: command, interrupt enable, configure flag, frame index, all status bits and all state machines. Bit 1 always reads 0.
- R5: Configure flag (offset 0x10): only bit 0 is stored; bits 31:1 read 0.
- R6: Interrupt enable (offset 0x08): only bits 5:0 are stored; bits 31:6 read 0.
- R7: The periodic status bit (14) switches to the periodic-enable command bit (bit 4) only on an edge where frame index bits 2:0 are zero. On any other edge it holds.
- R8: The async status bit (15) follows the async-enable command bit (bit 5) one clock after the command register changes, whether that change sets or clears it.
- R9: ev_sched_start sets the reclamation bit. ev_list_head clears the reclamation bit if it is set. If the bit is already clear, ev_list_head instead drives done_pulse high for the following cycle. When both events arrive together, the start event wins and no done pulse is produced.
- R10: An access whose address bits 1:0 are not zero is rejected: a write changes nothing and a read returns 0. Unmapped aligned offsets also read 0. A read returns the register as one 32-bit word, byte 0 in bits 7:0.
- R11: After reset: status reads 0x0000_1000 (HALTED only), command reads 0, frame index reads 0, irq is 0 and done_pulse is 0.
- R12: An ev_int_set bit sets its status bit on the next edge, and irq reflects it in that same cycle. The set wins over a simultaneous software clear of the same bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| ev_int_set | input | 6 | Interrupt status set mask from schedule engine |
| ev_sched_start | input | 1 | Schedule start event |
| ev_list_head | input | 1 | Head-of-list event |
| irq | output | 1 | Level interrupt |
| done_pulse | output | 1 | One-cycle "done processing" pulse |

## Verification
The assertions check the following on every cycle:
- HALTED is clear whenever the run bit has just risen.
- A controller-reset write leaves every register at its default.
- The periodic status only changes after a frame-boundary edge.
- The async status only rises after async-enable was seen.
- An event set is never lost to a simultaneous clear.
- A done pulse appears only after a head-of-list event that found the reclamation bit clear.
- Rejected reads return zero.

The bench scenarios cover the rest:
- The register masks under many write patterns.
- Exact frame index counting and freezing.
- The held periodic state between boundaries.
- The enabled and disabled interrupt combinations.
- The reset contents of every register.

// File: rtl/usbh_opreg_pkg.sv
package usbh_opreg_pkg;
    // Byte offsets decoded on the bus
    localparam int OFS_CMD  = 0;
    localparam int OFS_STS  = 4;
    localparam int OFS_IEN  = 8;
    localparam int OFS_FIDX = 12;
    localparam int OFS_CFG  = 16;

    // Command bit positions
    localparam int CMD_RUN   = 0;
    localparam int CMD_HCRST = 1;
    localparam int CMD_PSE   = 4;
    localparam int CMD_ASE   = 5;

    // Status layout
    localparam int N_INT    = 6;
    localparam int STS_HALT = 12;
    localparam int STS_REC  = 13;
    localparam int STS_PSS  = 14;
    localparam int STS_ASS  = 15;

    typedef enum logic {RUN_HALTED, RUN_ACTIVE} run_state_e;
    typedef enum logic {SCH_OFF, SCH_ON} sched_state_e;
endpackage

// File: rtl/usbh_uframe_timer.sv
module usbh_uframe_timer #(
    parameter int FIDX_W     = 14,
    parameter int UFRAME_CYC = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              running,
    input  logic              wr_en,
    input  logic [FIDX_W-1:0] wr_val,
    output logic [FIDX_W-1:0] fidx
);
    logic tick;

    generate
        if (UFRAME_CYC <= 1) begin : g_direct
            assign tick = running;
        end else begin : g_prescale
            localparam int CNT_W = $clog2(UFRAME_CYC);
            localparam logic [CNT_W-1:0] LAST = CNT_W'(UFRAME_CYC - 1);
            logic [CNT_W-1:0] cnt;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)                        cnt <= '0;
                else if (!running || soft_rst)     cnt <= '0;
                else if (cnt == LAST)              cnt <= '0;
                else                               cnt <= cnt + 1'b1;
            end
            assign tick = running && (cnt == LAST);
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        fidx <= '0;
        else if (soft_rst) fidx <= '0;
        else if (wr_en)    fidx <= wr_val;
        else if (tick)     fidx <= fidx + 1'b1;
    end
endmodule

// File: rtl/usbh_sched_fsm.sv
module usbh_sched_fsm
    import usbh_opreg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic soft_rst,
    input  logic run_d,
    input  logic pse,
    input  logic ase,
    input  logic frame_edge,
    output logic halted,
    output logic running,
    output logic pss,
    output logic ass
);
    run_state_e   run_q, run_n;
    sched_state_e per_q, per_n;
    sched_state_e asy_q, asy_n;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= RUN_HALTED;
            per_q <= SCH_OFF;
            asy_q <= SCH_OFF;
        end else begin
            run_q <= run_n;
            per_q <= per_n;
            asy_q <= asy_n;
        end
    end

    // next-state logic
    always_comb begin
        run_n = run_q;
        per_n = per_q;
        asy_n = asy_q;
        unique case (run_q)
            RUN_HALTED: if (run_d)  run_n = RUN_ACTIVE;   // START
            RUN_ACTIVE: if (!run_d) run_n = RUN_HALTED;   // STOP
        endcase
        unique case (per_q)
            SCH_OFF: if (frame_edge && pse)  per_n = SCH_ON;   // P_ENABLE
            SCH_ON:  if (frame_edge && !pse) per_n = SCH_OFF;  // P_DISABLE
        endcase
        unique case (asy_q)
            SCH_OFF: if (ase)  asy_n = SCH_ON;    // A_ENABLE
            SCH_ON:  if (!ase) asy_n = SCH_OFF;   // A_DISABLE
        endcase
        if (soft_rst) begin
            per_n = SCH_OFF;
            asy_n = SCH_OFF;
        end
    end

    // outputs
    always_comb begin
        halted  = (run_q == RUN_HALTED);
        running = (run_q == RUN_ACTIVE);
        pss     = (per_q == SCH_ON);
        ass     = (asy_q == SCH_ON);
    end

    // R7: periodic status moves only after a frame-boundary edge
    a_r7_pss_on_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        (pss != $past(pss)) |-> ($past(frame_edge) || $past(soft_rst)));

    // R8: async status rises only after enable was seen
    a_r8_ass_after_enable: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ass) |-> $past(ase));
endmodule

// File: rtl/usbh_sts_bits.sv
module usbh_sts_bits
    import usbh_opreg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_rst,
    input  logic [N_INT-1:0] clr_mask,
    input  logic [N_INT-1:0] set_mask,
    input  logic [N_INT-1:0] ien,
    input  logic             ev_sched_start,
    input  logic             ev_list_head,
    output logic [N_INT-1:0] int_bits,
    output logic             rec,
    output logic             done_pulse,
    output logic             irq
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            int_bits   <= '0;
            rec        <= 1'b0;
            done_pulse <= 1'b0;
        end else begin
            // set events win over software clear and controller reset
            int_bits   <= (soft_rst ? '0 : (int_bits & ~clr_mask)) | set_mask;
            if (ev_sched_start)                rec <= 1'b1;
            else if (soft_rst || ev_list_head) rec <= 1'b0;
            done_pulse <= ev_list_head && !rec && !ev_sched_start && !soft_rst;
        end
    end

    assign irq = |(int_bits & ien);

    // R12: a set event is never lost to a same-cycle clear
    a_r12_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_mask) |=> ((int_bits & $past(set_mask)) == $past(set_mask)));

    // R9: done pulse only when the head event found reclamation clear
    a_r9_done_when_clear: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |-> ($past(ev_list_head) && !$past(rec) && !$past(ev_sched_start)));
endmodule

// File: rtl/usbh_opreg_bank.sv
module usbh_opreg_bank
    import usbh_opreg_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int FIDX_W     = 14,
    parameter int UFRAME_CYC = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [N_INT-1:0]  ev_int_set,
    input  logic              ev_sched_start,
    input  logic              ev_list_head,
    output logic              irq,
    output logic              done_pulse
);
    localparam logic [31:0] HCRST_MASK = 32'(1) << CMD_HCRST;

    logic              aligned, wr;
    logic              cmd_wr, soft_rst;
    logic [31:0]       cmd_q, cmd_d;
    logic [N_INT-1:0]  ien_q, clr_mask, int_bits;
    logic              cfg_q;
    logic [FIDX_W-1:0] fidx;
    logic              halted, running, pss, ass, rec;
    logic [31:0]       sts_word;

    assign aligned  = (bus_addr[1:0] == 2'b00);
    assign wr       = bus_sel && bus_we && aligned;
    assign cmd_wr   = wr && (bus_addr == ADDR_W'(OFS_CMD));
    assign soft_rst = cmd_wr && bus_wdata[CMD_HCRST];
    assign clr_mask = (wr && (bus_addr == ADDR_W'(OFS_STS))) ? bus_wdata[N_INT-1:0] : '0;

    always_comb begin
        cmd_d = cmd_q;
        if (soft_rst)    cmd_d = '0;
        else if (cmd_wr) cmd_d = bus_wdata & ~HCRST_MASK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q <= '0;
            ien_q <= '0;
            cfg_q <= 1'b0;
        end else begin
            cmd_q <= cmd_d;
            if (soft_rst) begin
                ien_q <= '0;
                cfg_q <= 1'b0;
            end else if (wr) begin
                if (bus_addr == ADDR_W'(OFS_IEN)) ien_q <= bus_wdata[N_INT-1:0];
                if (bus_addr == ADDR_W'(OFS_CFG)) cfg_q <= bus_wdata[0];
            end
        end
    end

    usbh_uframe_timer #(.FIDX_W(FIDX_W), .UFRAME_CYC(UFRAME_CYC)) u_timer (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .running(running),
        .wr_en(wr && (bus_addr == ADDR_W'(OFS_FIDX))),
        .wr_val(bus_wdata[FIDX_W-1:0]), .fidx(fidx)
    );

    usbh_sched_fsm u_sched (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .run_d(cmd_d[CMD_RUN]),
        .pse(cmd_q[CMD_PSE]), .ase(cmd_q[CMD_ASE]), .frame_edge(fidx[2:0] == 3'd0),
        .halted(halted), .running(running), .pss(pss), .ass(ass)
    );

    usbh_sts_bits u_sts (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .clr_mask(clr_mask),
        .set_mask(ev_int_set), .ien(ien_q), .ev_sched_start(ev_sched_start),
        .ev_list_head(ev_list_head), .int_bits(int_bits), .rec(rec),
        .done_pulse(done_pulse), .irq(irq)
    );

    always_comb begin
        sts_word              = '0;
        sts_word[N_INT-1:0]   = int_bits;
        sts_word[STS_HALT]    = halted;
        sts_word[STS_REC]     = rec;
        sts_word[STS_PSS]     = pss;
        sts_word[STS_ASS]     = ass;
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_sel && aligned) begin
            case (bus_addr)
                ADDR_W'(OFS_CMD):  bus_rdata = cmd_q;
                ADDR_W'(OFS_STS):  bus_rdata = sts_word;
                ADDR_W'(OFS_IEN):  bus_rdata = 32'(ien_q);
                ADDR_W'(OFS_FIDX): bus_rdata = 32'(fidx);
                ADDR_W'(OFS_CFG):  bus_rdata = 32'(cfg_q);
                default:           bus_rdata = '0;
            endcase
        end
    end

    // R3: a rising run bit always comes with HALTED clear
    a_r3_run_clears_halt: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmd_q[CMD_RUN]) |-> !halted);

    // R4: controller reset leaves every register at its default
    a_r4_hcrst_defaults: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (cmd_q == '0 && halted && ien_q == '0 && !cfg_q && fidx == '0 && !pss && !ass));

    // R10: rejected accesses read zero
    a_r10_unaligned_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !aligned) |-> (bus_rdata == '0));
endmodule

// File: tb/usbh_opreg_bank_tb.sv
`timescale 1ns/1ps
module usbh_opreg_bank_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [5:0]  ev_int_set = '0;
    logic        ev_sched_start = 1'b0, ev_list_head = 1'b0;
    logic        irq, done_pulse;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    localparam logic [7:0] A_CMD = 8'h00, A_STS = 8'h04, A_IEN = 8'h08,
                           A_FIDX = 8'h0C, A_CFG = 8'h10;

    always #2.5 clk = ~clk;

    usbh_opreg_bank #(.ADDR_W(8), .FIDX_W(14), .UFRAME_CYC(1)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ev_int_set(ev_int_set), .ev_sched_start(ev_sched_start),
        .ev_list_head(ev_list_head), .irq(irq), .done_pulse(done_pulse)
    );

    // {addr, write data, expected readback}
    localparam int NV = 9;
    localparam logic [71:0] VEC [0:NV-1] = '{
        {8'h08, 32'hFFFF_FFFF, 32'h0000_003F},   // R6
        {8'h08, 32'h0000_0015, 32'h0000_0015},   // R6
        {8'h10, 32'hFFFF_FFFF, 32'h0000_0001},   // R5
        {8'h10, 32'hFFFF_FFFE, 32'h0000_0000},   // R5
        {8'h04, 32'hFFFF_FFFF, 32'h0000_1000},   // R1
        {8'h0C, 32'h0000_FFFF, 32'h0000_3FFF},   // R3
        {8'h0C, 32'h0000_0000, 32'h0000_0000},   // R3
        {8'h00, 32'hFFFF_FF00, 32'hFFFF_FF00},   // R4
        {8'h00, 32'h0000_0000, 32'h0000_0000}    // R4
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic bwr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic brd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic pulse_int(input logic [5:0] m);
        @(negedge clk); ev_int_set = m;
        @(negedge clk); ev_int_set = '0;
    endtask

    task automatic pulse_start();
        @(negedge clk); ev_sched_start = 1'b1;
        @(negedge clk); ev_sched_start = 1'b0;
    endtask

    task automatic pulse_head();
        @(negedge clk); ev_list_head = 1'b1;
        @(negedge clk); ev_list_head = 1'b0;
    endtask

    initial begin
        #500000;
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'd0, 32'd1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] rv, a0, a1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R11 reset state
        brd(A_STS, rv);  check("R11 status", rv, 32'h1000);
        brd(A_CMD, rv);  check("R11 command", rv, 32'h0);
        brd(A_FIDX, rv); check("R11 frame index", rv, 32'h0);
        check("R11 irq", {31'b0, irq}, 32'h0);
        check("R11 done", {31'b0, done_pulse}, 32'h0);

        // vector table: write then read back
        for (int i = 0; i < NV; i++) begin
            bwr(VEC[i][71:64], VEC[i][63:32]);
            brd(VEC[i][71:64], rv);
            check($sformatf("R1/R3/R4/R5/R6 vector %0d", i), rv, VEC[i][31:0]);
        end

        // R3 run/stop
        bwr(A_CMD, 32'h1);
        brd(A_STS, rv);  check("R3 halt cleared", rv, 32'h0);
        brd(A_FIDX, a0); brd(A_FIDX, a1);
        check("R3 index counts", a1, a0 + 32'd1);
        bwr(A_CMD, 32'h0);
        brd(A_STS, rv);  check("R3 halt set", rv, 32'h1000);
        brd(A_FIDX, a0); brd(A_FIDX, a1);
        check("R3 index frozen", a1, a0);

        // R7 periodic status on frame boundaries only
        bwr(A_FIDX, 32'd3);
        bwr(A_CMD, 32'h10);
        repeat (3) @(negedge clk);
        brd(A_STS, rv);  check("R7 held off boundary", rv, 32'h1000);
        bwr(A_FIDX, 32'd8);
        brd(A_STS, rv);  check("R7 on at boundary", rv, 32'h5000);
        bwr(A_FIDX, 32'd9);
        bwr(A_CMD, 32'h0);
        repeat (3) @(negedge clk);
        brd(A_STS, rv);  check("R7 held on off boundary", rv, 32'h5000);
        bwr(A_FIDX, 32'd16);
        brd(A_STS, rv);  check("R7 off at boundary", rv, 32'h1000);

        // R8 async status
        bwr(A_CMD, 32'h20);
        brd(A_STS, rv);  check("R8 async on", rv, 32'h9000);
        bwr(A_CMD, 32'h0);
        brd(A_STS, rv);  check("R8 async off", rv, 32'h1000);

        // R2 / R12 / R1 interrupts
        bwr(A_IEN, 32'h1);
        pulse_int(6'h04);
        check("R2 masked bit no irq", {31'b0, irq}, 32'h0);
        brd(A_STS, rv);  check("R12 bit set", rv, 32'h1004);
        pulse_int(6'h01);
        check("R12 irq same cycle", {31'b0, irq}, 32'h1);
        bwr(A_STS, 32'h0000_0004);
        brd(A_STS, rv);  check("R1 w1c one bit", rv, 32'h1001);
        check("R2 irq stays", {31'b0, irq}, 32'h1);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = A_STS; bus_wdata = 32'h1; ev_int_set = 6'h01;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0; ev_int_set = '0;
        brd(A_STS, rv);  check("R12 set beats clear", rv, 32'h1001);
        bwr(A_IEN, 32'h0);
        check("R2 enable off drops irq", {31'b0, irq}, 32'h0);
        bwr(A_IEN, 32'h1);
        check("R2 enable on raises irq", {31'b0, irq}, 32'h1);
        bwr(A_STS, 32'hFFFF_FFFF);
        brd(A_STS, rv);  check("R1 w1c all", rv, 32'h1000);
        check("R2 irq low after clear", {31'b0, irq}, 32'h0);

        // R9 reclamation and done pulse
        pulse_start();
        brd(A_STS, rv);  check("R9 rec set", rv, 32'h3000);
        pulse_head();
        check("R9 no done when set", {31'b0, done_pulse}, 32'h0);
        brd(A_STS, rv);  check("R9 rec cleared", rv, 32'h1000);
        pulse_head();
        check("R9 done pulse", {31'b0, done_pulse}, 32'h1);
        @(negedge clk);
        check("R9 done one cycle", {31'b0, done_pulse}, 32'h0);
        @(negedge clk); ev_sched_start = 1'b1; ev_list_head = 1'b1;
        @(negedge clk); ev_sched_start = 1'b0; ev_list_head = 1'b0;
        check("R9 start wins no done", {31'b0, done_pulse}, 32'h0);
        brd(A_STS, rv);  check("R9 start wins rec", rv, 32'h3000);

        // R4 controller reset
        bwr(A_IEN, 32'h3F);
        bwr(A_CFG, 32'h1);
        bwr(A_CMD, 32'h31);
        repeat (4) @(negedge clk);
        bwr(A_CMD, 32'h2);
        brd(A_CMD, rv);  check("R4 cmd", rv, 32'h0);
        brd(A_IEN, rv);  check("R4 ien", rv, 32'h0);
        brd(A_CFG, rv);  check("R4 cfg", rv, 32'h0);
        brd(A_STS, rv);  check("R4 sts", rv, 32'h1000);
        brd(A_FIDX, rv); check("R4 fidx", rv, 32'h0);
        bwr(A_CMD, 32'h3);
        brd(A_CMD, rv);  check("R4 reset bit not stored", rv, 32'h0);
        brd(A_STS, rv);  check("R4 stays halted", rv, 32'h1000);

        // R10 unaligned rejection
        bwr(A_IEN, 32'h2A);
        bwr(8'h09, 32'h3F);
        brd(A_IEN, rv);  check("R10 unaligned write ignored", rv, 32'h2A);
        brd(8'h09, rv);  check("R10 unaligned read zero", rv, 32'h0);
        brd(8'h40, rv);  check("R10 unmapped read zero", rv, 32'h0);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule